// File: doc/BRIEF.md
# Debug Halt Entry Controller

This block decides the cycle in which a processor core stops normal execution and halts into debug mode. Each cycle it samples strobes from the core's pipeline: an instruction captured in the instruction latch, an instruction completing execution, the abort of that completing instruction, a decoded software debug request with its evaluated condition, and breakpoint matches on program fetches and on data accesses. Each source is honoured at its own pipeline point. A software request waits for the next instruction latch. A program-fetch breakpoint is taken when the matched instruction completes. A data-access breakpoint is held until the following instruction completes. Trace stepping counts only instructions that are not aborted.

A small host register port loads the trace step counter and the breakpoint occurrence counter, and sets the two enable bits. It reports the halt status and cause, and issues the resume command. When entry is due, the block gives a one-cycle entry pulse, sets a sticky halted flag and records a cause code. It also keeps a copy of the last program data bus transfer made before the halt, so that a debugger can restore it later.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After a synchronous reset `dbg_entry`, `dbg_halted` and `dbg_cause` are 0. Every host register also reads 0.
- R2: When `swreq_valid` and `swreq_cond` are both high, a request becomes pending. Entry follows the first `ins_latch` in a later cycle: `dbg_entry` is high for the cycle after that latch cycle, and `dbg_cause` is 1.
- R3: A software request with `swreq_cond` low has no effect, and later `ins_latch` strobes cause no entry.
- R4: With trace enabled, a qualified completion (`ins_retire` high and `ins_abort` low) decrements a non-zero trace counter by one and causes no entry.
- R5: With trace enabled, a qualified completion while the trace counter reads 0 causes entry in the next cycle with `dbg_cause` 3.
- R6: A completion with `ins_abort` high does not change the trace counter and causes no entry.
- R7: With breakpoints enabled and a non-zero breakpoint counter, a breakpoint match on a qualified completion decrements the counter by one and causes no entry.
- R8: With breakpoints enabled and the counter at 0, `fetch_bp_hit` on a qualified completion causes entry in the next cycle with `dbg_cause` 2. With breakpoints disabled, matches are ignored.
- R9: With breakpoints enabled and the counter at 0, `data_bp_hit` on a qualified completion causes no entry itself. Entry follows the next qualified completion in a later cycle, with `dbg_cause` 2.
- R10: When several causes are due in one cycle, exactly one single-cycle pulse is raised. The cause code follows the priority software (1) over breakpoint (2) over trace (3).
- R11: While `dbg_halted` is set, all triggers are ignored, the counters hold, and the flag stays set. Writing 1 to bit 0 of the status register resumes: it clears the flag, sets the cause to 0, and drops any pending software request or delayed data breakpoint.
- R12: The snapshot register takes `pdb_data` on each `pdb_valid` cycle while not halted, and holds it while halted. A host write to the snapshot register overrides it.
- R13: Host map, with read data registered one cycle after `host_addr`:
  - 0: control register. Bit 0 is trace enable, bit 1 is breakpoint enable.
  - 1: trace counter.
  - 2: breakpoint counter.
  - 3: snapshot register.
  - 4: status register. Bit 0 is halted and bits 2:1 are the cause.
  - Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_latch | input | 1 | An instruction entered the instruction latch |
| ins_retire | input | 1 | An instruction completed execution |
| ins_abort | input | 1 | The completing instruction was aborted |
| swreq_valid | input | 1 | A software debug request is executing |
| swreq_cond | input | 1 | Condition result of that request |
| fetch_bp_hit | input | 1 | The completing instruction matched a fetch breakpoint |
| data_bp_hit | input | 1 | The completing instruction matched a data breakpoint |
| pdb_valid | input | 1 | Program data bus transfer this cycle |
| pdb_data | input | DATA_W | Program data bus value |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| dbg_entry | output | 1 | One-cycle debug entry pulse |
| dbg_halted | output | 1 | Sticky halted flag |
| dbg_cause | output | 2 | Entry cause: 0 none, 1 software, 2 breakpoint, 3 trace |

## Verification
Every entry result appears one clock after the cycle whose strobes make it due, because the pulse, flag and cause are registers fed from that cycle's inputs. The deferred sources therefore show their lag in strobe cycles, not in clock cycles: a software request waits for a later latch strobe, and a data breakpoint waits for a later completion. The bench drives strobes on the falling edge and reads outputs on the next falling edge, one rising edge later. It also inserts idle cycles between the deferring strobe and the releasing strobe to show that no entry leaks in between. Counter values are read through the host port. A read returns the state before the edge it samples, so each read is made in a cycle that carries no other stimulus.

// File: rtl/dbg_entry_pkg.sv
`timescale 1ns/1ps
package dbg_entry_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_SW    = 2'd1,
    CAUSE_BP    = 2'd2,
    CAUSE_TRACE = 2'd3
  } cause_e;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_TRACE = 3'd1;
  localparam logic [2:0] REG_BPCNT = 3'd2;
  localparam logic [2:0] REG_SNAP  = 3'd3;
  localparam logic [2:0] REG_STAT  = 3'd4;
endpackage

// File: rtl/dbg_trace_step.sv
`timescale 1ns/1ps
module dbg_trace_step #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halted,
  input  logic             en,
  input  logic             retire_ok,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             due
);
  logic at_zero;
  assign at_zero = (cnt == '0);
  assign due     = !halted && en && retire_ok && at_zero;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (ld)
      cnt <= ld_val;
    else if (!halted && en && retire_ok && !at_zero)
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/dbg_bp_gate.sv
`timescale 1ns/1ps
module dbg_bp_gate #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halted,
  input  logic             en,
  input  logic             retire_ok,
  input  logic             fetch_hit,
  input  logic             data_hit,
  input  logic             flush,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             data_pend,
  output logic             due
);
  logic at_zero, match;
  assign at_zero = (cnt == '0);
  assign match   = !halted && en && retire_ok && (fetch_hit || data_hit);
  assign due     = !halted && retire_ok &&
                   ((en && fetch_hit && at_zero) || data_pend);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (ld)
      cnt <= ld_val;
    else if (match && !at_zero)
      cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush || due)
      data_pend <= 1'b0;
    else if (match && data_hit && at_zero)
      data_pend <= 1'b1;
  end
endmodule

// File: rtl/dbg_entry_ctrl.sv
`timescale 1ns/1ps
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_latch,
  input  logic              ins_retire,
  input  logic              ins_abort,
  input  logic              swreq_valid,
  input  logic              swreq_cond,
  input  logic              fetch_bp_hit,
  input  logic              data_bp_hit,
  input  logic              pdb_valid,
  input  logic [DATA_W-1:0] pdb_data,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dbg_entry,
  output logic              dbg_halted,
  output logic [1:0]        dbg_cause
);
  logic              trace_en, bp_en, sw_pend;
  logic              retire_ok, resume, fire;
  logic              sw_due, bp_due, tr_due, data_pend;
  logic [CNT_W-1:0]  trace_cnt, bp_cnt;
  logic [DATA_W-1:0] snap;
  cause_e            cause_q, cause_d;

  assign retire_ok = ins_retire && !ins_abort;
  assign resume    = host_we && (host_addr == REG_STAT) && host_wdata[0];
  assign sw_due    = !dbg_halted && sw_pend && ins_latch;
  assign fire      = !dbg_halted && (sw_due || bp_due || tr_due);

  always_comb begin
    if (sw_due)      cause_d = CAUSE_SW;
    else if (bp_due) cause_d = CAUSE_BP;
    else             cause_d = CAUSE_TRACE;
  end

  dbg_trace_step #(.CNT_W(CNT_W)) u_trace (
    .clk(clk), .rst(rst), .halted(dbg_halted), .en(trace_en),
    .retire_ok(retire_ok),
    .ld(host_we && host_addr == REG_TRACE),
    .ld_val(host_wdata[CNT_W-1:0]),
    .cnt(trace_cnt), .due(tr_due)
  );

  dbg_bp_gate #(.CNT_W(CNT_W)) u_bp (
    .clk(clk), .rst(rst), .halted(dbg_halted), .en(bp_en),
    .retire_ok(retire_ok), .fetch_hit(fetch_bp_hit), .data_hit(data_bp_hit),
    .flush(resume || fire),
    .ld(host_we && host_addr == REG_BPCNT),
    .ld_val(host_wdata[CNT_W-1:0]),
    .cnt(bp_cnt), .data_pend(data_pend), .due(bp_due)
  );

  // software request waits for a later latch strobe
  always_ff @(posedge clk) begin
    if (rst || resume || fire)
      sw_pend <= 1'b0;
    else if (!dbg_halted && swreq_valid && swreq_cond)
      sw_pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_entry  <= 1'b0;
      dbg_halted <= 1'b0;
      cause_q    <= CAUSE_NONE;
    end else begin
      dbg_entry <= fire;
      if (fire) begin
        dbg_halted <= 1'b1;
        cause_q    <= cause_d;
      end else if (resume) begin
        dbg_halted <= 1'b0;
        cause_q    <= CAUSE_NONE;
      end
    end
  end
  assign dbg_cause = cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trace_en <= 1'b0;
      bp_en    <= 1'b0;
      snap     <= '0;
    end else begin
      if (host_we && host_addr == REG_CTRL) begin
        trace_en <= host_wdata[0];
        bp_en    <= host_wdata[1];
      end
      if (host_we && host_addr == REG_SNAP)
        snap <= host_wdata;
      else if (pdb_valid && !dbg_halted)
        snap <= pdb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else begin
      case (host_addr)
        REG_CTRL:  host_rdata <= DATA_W'({bp_en, trace_en});
        REG_TRACE: host_rdata <= DATA_W'(trace_cnt);
        REG_BPCNT: host_rdata <= DATA_W'(bp_cnt);
        REG_SNAP:  host_rdata <= snap;
        REG_STAT:  host_rdata <= DATA_W'({cause_q, dbg_halted});
        default:   host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_entry_chk.sv
`timescale 1ns/1ps
module dbg_entry_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_latch,
  input logic             ins_retire,
  input logic             ins_abort,
  input logic             host_we,
  input logic [2:0]       host_addr,
  input logic             resume,
  input logic [CNT_W-1:0] trace_cnt,
  input logic             dbg_entry,
  input logic             dbg_halted,
  input logic [1:0]       dbg_cause
);
  // R10
  entry_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_entry |=> !dbg_entry);

  // R10
  entry_sets_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_entry |-> (dbg_halted && dbg_cause != 2'd0));

  // R11
  entry_from_running_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_entry |-> $past(!dbg_halted));

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_halted && !resume) |=> dbg_halted);

  // R2
  sw_needs_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_entry && dbg_cause == 2'd1) |-> $past(ins_latch));

  // R6
  abort_no_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((!ins_retire || ins_abort) && !(host_we && host_addr == 3'd1))
      |=> $stable(trace_cnt));
endmodule

bind dbg_entry_ctrl dbg_entry_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ins_latch(ins_latch), .ins_retire(ins_retire),
  .ins_abort(ins_abort), .host_we(host_we), .host_addr(host_addr),
  .resume(resume), .trace_cnt(trace_cnt), .dbg_entry(dbg_entry),
  .dbg_halted(dbg_halted), .dbg_cause(dbg_cause)
);

// File: tb/tb_dbg_entry_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_entry_ctrl;
  localparam int DW = 24;
  logic clk = 1'b0;
  logic rst;
  logic ins_latch, ins_retire, ins_abort, swreq_valid, swreq_cond;
  logic fetch_bp_hit, data_bp_hit, pdb_valid, host_we;
  logic [DW-1:0] pdb_data, host_wdata, host_rdata;
  logic [2:0] host_addr;
  logic dbg_entry, dbg_halted;
  logic [1:0] dbg_cause;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_entry_ctrl dut (.*);

  task automatic idle_inputs();
    ins_latch = 0; ins_retire = 0; ins_abort = 0; swreq_valid = 0;
    swreq_cond = 0; fetch_bp_hit = 0; data_bp_hit = 0; pdb_valid = 0;
    host_we = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    idle_inputs();
  endtask

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hwrite(logic [2:0] a, logic [DW-1:0] d);
    host_we = 1; host_addr = a; host_wdata = d; step();
  endtask

  task automatic hread(logic [2:0] a, output logic [DW-1:0] d);
    host_addr = a; step(); d = host_rdata;
  endtask

  task automatic resume_core();
    hwrite(3'd4, 24'h1);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1", "entry", DW'(dbg_entry), 0);
    chk("R1", "halted", DW'(dbg_halted), 0);
    chk("R1", "cause", DW'(dbg_cause), 0);
    for (int a = 0; a < 5; a++) begin
      hread(3'(a), v);
      chk("R1", "host reg", v, 0);
    end
  endtask

  task automatic t_sw();
    logic [DW-1:0] v;
    swreq_valid = 1; swreq_cond = 0; step();
    ins_latch = 1; step(); ins_latch = 1; step();
    chk("R3", "false request entry", DW'(dbg_entry), 0);
    chk("R3", "false request halted", DW'(dbg_halted), 0);
    swreq_valid = 1; swreq_cond = 1; ins_latch = 1; step();
    chk("R2", "no entry in request cycle", DW'(dbg_entry), 0);
    step(); step();
    chk("R2", "no entry before latch", DW'(dbg_entry), 0);
    ins_latch = 1; step();
    chk("R2", "entry after latch", DW'(dbg_entry), 1);
    chk("R2", "cause sw", DW'(dbg_cause), 1);
    step();
    chk("R2", "pulse width", DW'(dbg_entry), 0);
    hread(3'd4, v);
    chk("R13", "status reg", v, 24'h3);
    resume_core();
    chk("R11", "resume clears halted", DW'(dbg_halted), 0);
    chk("R11", "resume clears cause", DW'(dbg_cause), 0);
  endtask

  task automatic t_trace();
    logic [DW-1:0] v;
    hwrite(3'd1, 24'd1); hwrite(3'd0, 24'h1);
    hread(3'd0, v); chk("R13", "ctrl readback", v, 24'h1);
    ins_retire = 1; ins_abort = 1; step();
    chk("R6", "aborted no entry", DW'(dbg_entry), 0);
    hread(3'd1, v); chk("R6", "aborted keeps count", v, 24'd1);
    ins_retire = 1; step();
    chk("R4", "decrement no entry", DW'(dbg_entry), 0);
    hread(3'd1, v); chk("R4", "count after retire", v, 24'd0);
    ins_retire = 1; ins_abort = 1; step();
    chk("R6", "aborted at zero", DW'(dbg_entry), 0);
    ins_retire = 1; step();
    chk("R5", "trace entry", DW'(dbg_entry), 1);
    chk("R5", "cause trace", DW'(dbg_cause), 3);
    step();
    ins_retire = 1; fetch_bp_hit = 1; swreq_valid = 1; swreq_cond = 1; step();
    ins_latch = 1; ins_retire = 1; step();
    chk("R11", "halted ignores entry", DW'(dbg_entry), 0);
    chk("R11", "cause held", DW'(dbg_cause), 3);
    chk("R11", "halted held", DW'(dbg_halted), 1);
    hwrite(3'd0, 24'h0);
    resume_core();
    ins_latch = 1; step();
    chk("R11", "sw request during halt dropped", DW'(dbg_entry), 0);
  endtask

  task automatic t_bp();
    logic [DW-1:0] v;
    hwrite(3'd0, 24'h0); hwrite(3'd2, 24'd0);
    ins_retire = 1; fetch_bp_hit = 1; step();
    chk("R8", "disabled bp ignored", DW'(dbg_entry), 0);
    hwrite(3'd2, 24'd1); hwrite(3'd0, 24'h2);
    ins_retire = 1; fetch_bp_hit = 1; step();
    chk("R7", "counted hit no entry", DW'(dbg_entry), 0);
    hread(3'd2, v); chk("R7", "bp count", v, 24'd0);
    ins_retire = 1; fetch_bp_hit = 1; step();
    chk("R8", "fetch bp entry", DW'(dbg_entry), 1);
    chk("R8", "cause bp", DW'(dbg_cause), 2);
    resume_core();
    ins_retire = 1; data_bp_hit = 1; step();
    chk("R9", "data hit deferred", DW'(dbg_entry), 0);
    step(); ins_latch = 1; step();
    chk("R9", "no entry while idle", DW'(dbg_entry), 0);
    ins_retire = 1; step();
    chk("R9", "data bp entry", DW'(dbg_entry), 1);
    chk("R9", "cause bp", DW'(dbg_cause), 2);
    resume_core();
    ins_retire = 1; data_bp_hit = 1; step();
    resume_core();
    ins_retire = 1; step();
    chk("R11", "resume drops data pend", DW'(dbg_entry), 0);
    hwrite(3'd0, 24'h0);
  endtask

  task automatic t_prio();
    hwrite(3'd1, 24'd0); hwrite(3'd2, 24'd0); hwrite(3'd0, 24'h3);
    swreq_valid = 1; swreq_cond = 1; step();
    ins_latch = 1; ins_retire = 1; fetch_bp_hit = 1; step();
    chk("R10", "one pulse", DW'(dbg_entry), 1);
    chk("R10", "sw wins", DW'(dbg_cause), 1);
    step();
    chk("R10", "pulse ends", DW'(dbg_entry), 0);
    resume_core();
    ins_retire = 1; fetch_bp_hit = 1; step();
    chk("R10", "bp over trace", DW'(dbg_cause), 2);
    hwrite(3'd0, 24'h0);
    resume_core();
  endtask

  task automatic t_snap();
    logic [DW-1:0] v;
    pdb_valid = 1; pdb_data = 24'h123456; step();
    pdb_valid = 1; pdb_data = 24'hABCDEF; step();
    swreq_valid = 1; swreq_cond = 1; step();
    ins_latch = 1; step();
    chk("R12", "halted for snapshot", DW'(dbg_halted), 1);
    pdb_valid = 1; pdb_data = 24'h555555; step();
    hread(3'd3, v); chk("R12", "snapshot held", v, 24'hABCDEF);
    hwrite(3'd3, 24'h0F0F0F);
    hread(3'd3, v); chk("R12", "host write snapshot", v, 24'h0F0F0F);
    resume_core();
  endtask

  initial begin
    idle_inputs(); host_addr = 0; host_wdata = 0; pdb_data = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset(); t_sw(); t_trace(); t_bp(); t_prio(); t_snap();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule